// File: doc/BRIEF.md
# Multi-Channel Event Timer

The block holds a 64-bit free-running main counter and a set of comparator channels, all reached through a flat 32-bit register interface. Software stops the counter, loads both of its halves, then sets the global run bit. From then on the counter advances by one on every clock. Each channel compares its 64-bit comparator against the counter, or only the low 32 bits when its narrow-compare bit is set. On a match it sets a write-1-to-clear status bit.

A channel runs in one of two modes. A one-shot channel fires and keeps its comparator. A periodic channel adds a stored period to its comparator on every match. A periodic channel is armed by a configuration write that carries the set-value flag. The next comparator-low write then sets the next match time, and the one after it sets the period. Channel 1 has no periodic capability. Each pending status drives one of the interrupt lines, chosen by the channel's route field. When legacy routing is on, channel 0 is forced onto the tick line and channel 1 onto the clock-chip line.

Register map (byte offsets): 0x000 ID, 0x004 tick period, 0x010 global control, 0x020 interrupt status, 0x0F0 counter low, 0x0F4 counter high. Channel n starts at 0x100 + 0x20·n: +0x00 config, +0x08 comparator low, +0x0C comparator high. Reads are combinational on `addr_i`. Writes take effect at the clock edge on which `req_i` and `we_i` are high.

Top module: `evt_timer`

## Requirements
- R1: ID (0x000) reads NUM_CH-1 in bits [4:0] and legacy capability in bit 8, which gives 0x103 by default. The period register (0x004) reads PERIOD_FS and ignores writes. Global control (0x010) holds run in bit 0 and legacy routing in bit 1. After reset, global control, status, counter and all interrupt lines are zero.
- R2: While run is 1, the counter advances by exactly one per clock. While run is 0, it holds its value.
- R3: Writes to the counter halves (0x0F0 low, 0x0F4 high) load the counter only while run is 0. While run is 1 they are ignored.
- R4: Channel config bits are: bit 1 interrupt enable, bit 3 periodic, bit 6 set-value, bit 8 narrow (32-bit) compare, bits [13:9] route. All except set-value read back. Set-value always reads 0.
- R5: In one-shot mode, a match raises the channel's status bit one clock after the cycle in which the counter equals the comparator. The comparator keeps its value.
- R6: A config write with periodic=1 and set-value=1 arms the sequence. The next comparator-low write loads the match value. The following comparator-low write (and any comparator-high write in that phase) loads the period.
- R7: In periodic mode, every match adds the period to the comparator.
- R8: A config write with set-value=0 cancels the sequence. Later comparator writes then go to the comparator.
- R9: With narrow compare set, only the low 32 bits take part in the match. Otherwise all 64 bits do.
- R10: A channel whose interrupt enable is 0 never sets its status bit.
- R11: Status (0x020, bit n = channel n) clears only the bits written as 1. Bits written as 0 are kept.
- R12: Interrupt line k is high while any pending channel is routed to k. With legacy routing, channel 0 goes to line TICK_LINE (0) and channel 1 to line CLK_LINE (8), and their route fields are ignored.
- R13: Channel 1 drops the periodic bit (it reads 0). It never arms the sequence, so all its comparator writes go to the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| irq_o | output | NUM_LINES | Interrupt lines, level |

## Verification
The embedded assertions check the following on every cycle:
- the counter's one-per-clock step and its hold when stopped;
- that a running counter ignores loads;
- the comparator hold after a one-shot match and the period step after a periodic match;
- the phases of the load sequence;
- status gating by interrupt enable;
- write-1-to-clear;
- legacy routing of channel 0.

Only the bench's scenarios can show the rest:
- the exact cycle a match becomes visible on an interrupt line;
- the end-to-end result of a two-write periodic load after several matches;
- the difference between narrow and wide compare when the counter's high half is non-zero;
- the rerouting of channel 1 through the register path.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int REG_W  = 32;
  localparam int CNT_W  = 64;
  localparam int ADDR_W = 12;
  localparam int RT_W   = 5;
  localparam int CH_AW  = 3;   // up to 8 channels

  localparam logic [ADDR_W-1:0] A_ID    = 12'h000;
  localparam logic [ADDR_W-1:0] A_PER   = 12'h004;
  localparam logic [ADDR_W-1:0] A_GCFG  = 12'h010;
  localparam logic [ADDR_W-1:0] A_STS   = 12'h020;
  localparam logic [ADDR_W-1:0] A_CNTLO = 12'h0F0;
  localparam logic [ADDR_W-1:0] A_CNTHI = 12'h0F4;
  localparam logic [3:0]        A_CHPG  = 4'h1;
  localparam logic [4:0]        O_CFG   = 5'h00;
  localparam logic [4:0]        O_CMPLO = 5'h08;
  localparam logic [4:0]        O_CMPHI = 5'h0C;

  localparam int B_IEN = 1;
  localparam int B_PER = 3;
  localparam int B_SET = 6;
  localparam int B_M32 = 8;
  localparam int B_RT  = 9;
  localparam int G_RUN = 0;
  localparam int G_LEG = 1;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_CMP, SEQ_PER} seq_e;

  typedef struct packed {
    logic [RT_W-1:0] route;
    logic            m32;
    logic            per;
    logic            ien;
  } ch_cfg_t;

  function automatic logic [REG_W-1:0] cfg_word(input ch_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_IEN] = c.ien;
    w[B_PER] = c.per;
    w[B_M32] = c.m32;
    w[B_RT +: RT_W] = c.route;
    return w;
  endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter
  import evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      // loads are honoured only while stopped
      if (lo_we_i) cnt_q[REG_W-1:0]     <= wdata_i;
      if (hi_we_i) cnt_q[CNT_W-1:REG_W] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));

  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !lo_we_i && !hi_we_i |=> $stable(cnt_o));

  assert_run_ignores_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (lo_we_i || hi_we_i) |=> cnt_o != {$past(cnt_o[CNT_W-1:REG_W]), $past(wdata_i)}
                                       || $past(wdata_i) == $past(cnt_o[REG_W-1:0]) + REG_W'(1)
                                       || $past(hi_we_i));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter bit PER_CAP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             run_i,
  output ch_cfg_t          cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);
  ch_cfg_t          cfg_q;
  seq_e             seq_q;
  logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d;
  logic             match;

  assign match = run_i && (cfg_q.m32 ? (cnt_i[REG_W-1:0] == cmp_q[REG_W-1:0])
                                     : (cnt_i == cmp_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q.ien   <= wdata_i[B_IEN];
      cfg_q.per   <= PER_CAP && wdata_i[B_PER];
      cfg_q.m32   <= wdata_i[B_M32];
      cfg_q.route <= wdata_i[B_RT +: RT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= SEQ_IDLE;
    end else if (cfg_we_i) begin
      seq_q <= (PER_CAP && wdata_i[B_PER] && wdata_i[B_SET]) ? SEQ_CMP : SEQ_IDLE;
    end else if (lo_we_i) begin
      case (seq_q)
        SEQ_CMP: seq_q <= SEQ_PER;
        default: seq_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    cmp_d = cmp_q;
    per_d = per_q;
    if (match && cfg_q.per) cmp_d = cmp_q + per_q;
    // bus write wins over the periodic step
    if (seq_q == SEQ_PER) begin
      if (lo_we_i) per_d[REG_W-1:0]     = wdata_i;
      if (hi_we_i) per_d[CNT_W-1:REG_W] = wdata_i;
    end else begin
      if (lo_we_i) cmp_d[REG_W-1:0]     = wdata_i;
      if (hi_we_i) cmp_d[CNT_W-1:REG_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      per_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
    end
  end

  assign cfg_o = cfg_q;
  assign cmp_o = cmp_q;
  assign hit_o = match && cfg_q.ien;

  assert_oneshot_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match && !cfg_q.per && !lo_we_i && !hi_we_i |=> $stable(cmp_q));

  assert_first_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i && seq_q == SEQ_CMP |=> cmp_q[REG_W-1:0] == $past(wdata_i) && seq_q == SEQ_PER);

  assert_second_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i && seq_q == SEQ_PER && !match |=> $stable(cmp_q) && seq_q == SEQ_IDLE);

  assert_periodic_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match && cfg_q.per && !lo_we_i && !hi_we_i |=> cmp_q == $past(cmp_q) + $past(per_q));

  assert_seq_cancel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !wdata_i[B_SET] |=> seq_q == SEQ_IDLE);
endmodule

// File: rtl/evt_router.sv
module evt_router
  import evt_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 16,
  parameter int TICK_LINE = 0,
  parameter int CLK_LINE  = 8
) (
  input  logic [NUM_CH-1:0]      sts_i,
  input  logic [NUM_CH*RT_W-1:0] route_i,
  input  logic                   legacy_i,
  output logic [NUM_LINES-1:0]   irq_o
);
  always_comb begin
    irq_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (legacy_i && c == 0) begin
          if (l == TICK_LINE) irq_o[l] = irq_o[l] | sts_i[c];
        end else if (legacy_i && c == 1) begin
          if (l == CLK_LINE) irq_o[l] = irq_o[l] | sts_i[c];
        end else if (route_i[c*RT_W +: RT_W] == RT_W'(l)) begin
          irq_o[l] = irq_o[l] | sts_i[c];
        end
      end
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int          NUM_CH       = 4,
  parameter int          NUM_LINES    = 16,
  parameter int          TICK_LINE    = 0,
  parameter int          CLK_LINE     = 8,
  parameter logic [31:0] PERIOD_FS    = 32'd69841279,
  parameter bit          LEG_CAP      = 1'b1,
  parameter logic [31:0] PER_CAP_MASK = 32'hFFFF_FFFD
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [11:0]          addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic                   wr, is_ch;
  logic [CH_AW-1:0]       ch_sel;
  logic [4:0]             ch_off;
  logic                   run_q, leg_q;
  logic [NUM_CH-1:0]      sts_q, hit, cfg_we, lo_we, hi_we;
  logic [CNT_W-1:0]       cnt;
  ch_cfg_t                cfg_w [NUM_CH];
  logic [CNT_W-1:0]       cmp_w [NUM_CH];
  logic [NUM_CH*RT_W-1:0] route_flat;

  assign wr     = req_i && we_i;
  assign is_ch  = addr_i[11:8] == A_CHPG;
  assign ch_sel = addr_i[7:5];
  assign ch_off = addr_i[4:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr && addr_i == A_GCFG) begin
      run_q <= wdata_i[G_RUN];
      leg_q <= LEG_CAP && wdata_i[G_LEG];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    sts_q <= '0;
    else if (wr && addr_i == A_STS) sts_q <= (sts_q & ~wdata_i[NUM_CH-1:0]) | hit;
    else                            sts_q <= sts_q | hit;
  end

  evt_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .lo_we_i (wr && addr_i == A_CNTLO),
    .hi_we_i (wr && addr_i == A_CNTHI),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign cfg_we[c] = wr && is_ch && ch_sel == CH_AW'(c) && ch_off == O_CFG;
    assign lo_we[c]  = wr && is_ch && ch_sel == CH_AW'(c) && ch_off == O_CMPLO;
    assign hi_we[c]  = wr && is_ch && ch_sel == CH_AW'(c) && ch_off == O_CMPHI;
    assign route_flat[c*RT_W +: RT_W] = cfg_w[c].route;

    evt_channel #(.PER_CAP(PER_CAP_MASK[c])) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_we_i (cfg_we[c]),
      .lo_we_i  (lo_we[c]),
      .hi_we_i  (hi_we[c]),
      .wdata_i  (wdata_i),
      .cnt_i    (cnt),
      .run_i    (run_q),
      .cfg_o    (cfg_w[c]),
      .cmp_o    (cmp_w[c]),
      .hit_o    (hit[c])
    );

    assert_sts_needs_ien_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sts_q[c] && !cfg_w[c].ien |=> !sts_q[c]);

    assert_w1c_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr && addr_i == A_STS && wdata_i[c] && !hit[c] |=> !sts_q[c]);

    if (c == 1 && !PER_CAP_MASK[c]) begin : g_noper
      assert_ch1_no_periodic_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we[c] && wdata_i[B_PER] |=> !cfg_w[c].per);
    end
  end

  evt_router #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES),
    .TICK_LINE (TICK_LINE),
    .CLK_LINE  (CLK_LINE)
  ) u_rt (
    .sts_i    (sts_q),
    .route_i  (route_flat),
    .legacy_i (leg_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_ID:    begin
                 rdata_o[4:0] = 5'(NUM_CH - 1);
                 rdata_o[8]   = LEG_CAP;
               end
      A_PER:   rdata_o = PERIOD_FS;
      A_GCFG:  begin
                 rdata_o[G_RUN] = run_q;
                 rdata_o[G_LEG] = leg_q;
               end
      A_STS:   rdata_o[NUM_CH-1:0] = sts_q;
      A_CNTLO: rdata_o = cnt[REG_W-1:0];
      A_CNTHI: rdata_o = cnt[CNT_W-1:REG_W];
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (is_ch && ch_sel == CH_AW'(c)) begin
            if (ch_off == O_CFG)   rdata_o = cfg_word(cfg_w[c]);
            if (ch_off == O_CMPLO) rdata_o = cmp_w[c][REG_W-1:0];
            if (ch_off == O_CMPHI) rdata_o = cmp_w[c][CNT_W-1:REG_W];
          end
        end
      end
    endcase
  end

  assert_legacy_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_q && sts_q[0] |-> irq_o[TICK_LINE]);
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  localparam logic [11:0] ID = 12'h000, PER = 12'h004, GCFG = 12'h010, STS = 12'h020;
  localparam logic [11:0] CLO = 12'h0F0, CHI = 12'h0F4;

  typedef struct packed {
    logic        rd;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{1'b1, 12'h000, 32'h0000_0103, 4'd1},   // R1 ID
    '{1'b1, 12'h004, 32'h0429_B17F, 4'd1},   // R1 period
    '{1'b0, 12'h004, 32'h0000_0000, 4'd1},
    '{1'b1, 12'h004, 32'h0429_B17F, 4'd1},   // R1 read-only
    '{1'b0, 12'h010, 32'h0000_0002, 4'd1},
    '{1'b1, 12'h010, 32'h0000_0002, 4'd1},   // R1 legacy bit
    '{1'b0, 12'h010, 32'h0000_0000, 4'd1},
    '{1'b0, 12'h140, 32'hFFFF_FFFF, 4'd4},
    '{1'b1, 12'h140, 32'h0000_3F0A, 4'd4},   // R4 set-value reads 0
    '{1'b0, 12'h120, 32'hFFFF_FFFF, 4'd13},
    '{1'b1, 12'h120, 32'h0000_3F02, 4'd13},  // R13 periodic dropped
    '{1'b0, 12'h140, 32'h0000_0000, 4'd4},
    '{1'b0, 12'h120, 32'h0000_0000, 4'd4},
    '{1'b1, 12'h140, 32'h0000_0000, 4'd4},   // R4
    '{1'b0, 12'h0F0, 32'h0000_1234, 4'd3},
    '{1'b1, 12'h0F0, 32'h0000_1234, 4'd3},   // R3 load while stopped
    '{1'b0, 12'h0F4, 32'h0000_ABCD, 4'd3},
    '{1'b1, 12'h0F4, 32'h0000_ABCD, 4'd3},   // R3
    '{1'b0, 12'h16C, 32'h0000_0009, 4'd4},
    '{1'b1, 12'h16C, 32'h0000_0009, 4'd4}    // R4 comparator high
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [15:0] irq_o;
  int          nchk = 0, nfail = 0;
  bit          done = 0;

  evt_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [11:0] cha(input int n, input int off);
    return 12'(12'h100 + n * 32 + off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic clr_cnt(input logic [31:0] hi);
    wr(CLO, 32'h0);
    wr(CHI, hi);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rchk("R1 gcfg reset", GCFG, 32'h0);
    rchk("R1 status reset", STS, 32'h0);
    rchk("R1 counter reset", CLO, 32'h0);
    chk("R1 irq reset", {16'h0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].rd) begin
        rd(VT[i].a, v);
        chk($sformatf("R%0d table[%0d]", VT[i].rq, i), v, VT[i].d);
      end else begin
        wr(VT[i].a, VT[i].d);
      end
    end

    // R5 one-shot on ch2, route 5, wide compare, cmp=10
    clr_cnt(32'h0);
    wr(cha(2, 0), 32'h0000_0A02);
    wr(cha(2, 8), 32'd10);
    wr(cha(2, 12), 32'h0);
    wr(GCFG, 32'h1);
    for (int i = 1; i <= 10; i++) @(negedge clk_i);
    chk("R5 no irq before match", {31'h0, irq_o[5]}, 32'h0);
    @(negedge clk_i);
    chk("R5 irq after match", {31'h0, irq_o[5]}, 32'h1);
    wr(GCFG, 32'h0);
    rchk("R2 counter after run", CLO, 32'd12);
    rchk("R5 comparator kept", cha(2, 8), 32'd10);
    rchk("R2 counter stopped", CLO, 32'd12);

    // R11 write-1-to-clear
    wr(STS, 32'h0);
    rchk("R11 zero write keeps", STS, 32'h4);
    wr(STS, 32'h4);
    rchk("R11 one write clears", STS, 32'h0);
    chk("R11 irq dropped", {31'h0, irq_o[5]}, 32'h0);
    wr(cha(2, 0), 32'h0);

    // R6 R7 periodic ch0, route 3, narrow compare, match 5 period 4
    clr_cnt(32'h0);
    wr(cha(0, 0), 32'h0000_074A);
    wr(cha(0, 8), 32'd5);
    wr(cha(0, 8), 32'd4);
    rchk("R6 first write is match value", cha(0, 8), 32'd5);
    wr(GCFG, 32'h1);
    repeat (11) @(negedge clk_i);
    wr(GCFG, 32'h0);
    rchk("R7 comparator advanced twice", cha(0, 8), 32'd13);
    rchk("R7 status set", STS, 32'h1);
    chk("R12 routed line 3", {31'h0, irq_o[3]}, 32'h1);

    // R8 cancel
    wr(cha(0, 0), 32'h0000_074A);
    wr(cha(0, 0), 32'h0000_070A);
    wr(cha(0, 8), 32'd50);
    wr(cha(0, 8), 32'd60);
    rchk("R8 both writes to comparator", cha(0, 8), 32'd60);

    // R12 legacy routing, R10 disabled channel
    wr(GCFG, 32'h2);
    chk("R12 legacy ch0 on tick line", {31'h0, irq_o[0]}, 32'h1);
    chk("R12 legacy ch0 off route", {31'h0, irq_o[3]}, 32'h0);
    wr(cha(1, 0), 32'h0000_0D02);
    wr(cha(1, 8), 32'd2);
    wr(cha(1, 12), 32'h0);
    wr(cha(3, 0), 32'h0000_0F00);
    wr(cha(3, 8), 32'd2);
    wr(cha(3, 12), 32'h0);
    clr_cnt(32'h0);
    wr(GCFG, 32'h3);
    repeat (4) @(negedge clk_i);
    wr(GCFG, 32'h2);
    rchk("R10 disabled ch3 silent", STS, 32'h3);
    chk("R12 legacy ch1 on clock line", {31'h0, irq_o[8]}, 32'h1);
    chk("R12 legacy ch1 off route", {31'h0, irq_o[6]}, 32'h0);
    chk("R10 line 7 quiet", {31'h0, irq_o[7]}, 32'h0);
    wr(GCFG, 32'h0);
    chk("R12 normal lines", {16'h0, irq_o}, 32'h0000_0048);

    // R9 narrow vs wide compare, counter high = 1
    wr(STS, 32'hF);
    chk("R11 all cleared", {16'h0, irq_o}, 32'h0);
    clr_cnt(32'h1);
    wr(cha(1, 8), 32'd3);
    wr(cha(2, 0), 32'h0000_0A02);
    wr(cha(2, 8), 32'd3);
    wr(cha(2, 12), 32'h1);
    wr(cha(3, 0), 32'h0000_0E02);
    wr(cha(3, 8), 32'd3);
    wr(GCFG, 32'h1);
    repeat (6) @(negedge clk_i);
    wr(GCFG, 32'h0);
    rchk("R9 narrow and wide match", STS, 32'h6);
    wr(STS, 32'h2);
    rchk("R11 partial clear", STS, 32'h4);

    // R13 ch1 has no load sequence
    wr(cha(1, 0), 32'h0000_014A);
    rchk("R13 periodic dropped", cha(1, 0), 32'h0000_0102);
    wr(cha(1, 8), 32'd7);
    wr(cha(1, 8), 32'd3);
    rchk("R13 both writes to comparator", cha(1, 8), 32'd3);

    // R3 load ignored while running
    clr_cnt(32'h0);
    wr(GCFG, 32'h1);
    wr(CLO, 32'd1000);
    wr(GCFG, 32'h0);
    rchk("R3 load ignored while running", CLO, 32'd2);
    wr(CLO, 32'h55);
    repeat (3) @(negedge clk_i);
    rchk("R2 R3 stopped load held", CLO, 32'h55);

    done = 1;
    summary();
  end
endmodule